// File: doc/BRIEF.md
# BCD Real-Time Clock and Calendar Core

This core keeps the time of day and the calendar date in packed BCD registers and advances them once per second. A 32,768 Hz reference arrives as a single-cycle enable on `tick_en`. A prescaler counts `TICK_DIV` enabled ticks to make each one-second step. A short carry sequencer then walks the seconds, minutes, hours, weekday, date, month and year registers in order, one register per clock cycle. It stops at the first register that does not wrap.

A byte-wide register port lets a serial bus front end read and load every location. The address space has 2^`ADDR_W` bytes. Addresses 0 to 6 hold the timekeeping bytes: seconds, minutes, century/hours, weekday, date, month, year. Address 7 is a control byte with no effect on counting. Every higher address is scratch RAM. Reads are combinational from the address. Writes take effect at the next clock edge.

The carry sequencer has eight named states. `ST_IDLE` waits for the one-second pulse, and the pulse moves it to `ST_SEC`. `ST_SEC` moves to `ST_MIN` when seconds wrap, and the chain goes on the same way to `ST_HOUR`. From `ST_HOUR` an hour wrap goes to `ST_DAY`, and `ST_DAY` always moves on to `ST_DATE`. A date wrap goes on to `ST_MONTH`, and a month wrap goes on to `ST_YEAR`. `ST_YEAR` always returns to `ST_IDLE`. Every other state returns to `ST_IDLE` when its register does not wrap, when the stop bit is set (`ST_SEC` only), or when a port write hits that state's register in that cycle.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset, the reads are seconds 00h, minutes 00h, hours 00h, weekday 01h, date 01h, month 01h, year 00h and control 00h.
- R2: With the stop bit clear, the seconds byte increments exactly once per `TICK_DIV` cycles in which `tick_en` is high. Cycles with `tick_en` low do not count.
- R3: Seconds and minutes count in BCD from 00 to 59. On a wrap to 00, the next register up advances.
- R4: Hours occupy bits 5:0 of address 2 in 24-hour BCD. A wrap from 23 to 00 advances both the weekday and the date.
- R5: The weekday occupies bits 2:0 of address 3 and counts 1 to 7. After 7 comes 1.
- R6: The date wraps to 01 after the 30th in months 04, 06, 09 and 11, and after the 31st in months 01, 03, 05, 07, 08, 10 and 12. The date wrap advances the month, and the month wraps from 12 to 01 while advancing the year.
- R7: In month 02 the date wraps after 29 when the BCD year is a multiple of four, and after 28 otherwise.
- R8: A year wrap from 99 to 00 inverts the century flag in bit 7 of address 2.
- R9: Bit 7 of the seconds byte is a stop bit. While it is set, the prescaler and all timekeeping registers hold their values.
- R10: A port write loads its register at the next clock edge. A write to address 0 also restarts the prescaler from zero.
- R11: When a port write and a carry step target the same register in the same cycle, the written value is kept. In that case no carry passes to the next register.
- R12: The control byte (address 7) and the scratch RAM (addresses 8 and up) keep what was written, and timekeeping never changes them.
- R13: Unused bits read as zero: minutes bit 7, hours bit 6, weekday bits 7:3, date bits 7:6 and month bits 7:5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle enable at the reference rate |
| reg_addr | input | ADDR_W | Register port address |
| reg_we | input | 1 | Register port write strobe |
| reg_wdata | input | 8 | Register port write data |
| reg_rdata | output | 8 | Register port read data for `reg_addr` |

## Verification
The bench builds the core with `TICK_DIV` = 16 and keeps `tick_en` high. One second therefore lasts sixteen clock cycles. This lets the bench check the exact cycle in which seconds step and place a port write in the same cycle as the seconds carry step. `ADDR_W` stays at 6, so both ends of the scratch RAM and every month-end, leap-year and century rollover can be reached within a few hundred cycles.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEC,
        ST_MIN,
        ST_HOUR,
        ST_DAY,
        ST_DATE,
        ST_MONTH,
        ST_YEAR
    } rtc_state_e;

    localparam int unsigned A_SEC  = 0;
    localparam int unsigned A_MIN  = 1;
    localparam int unsigned A_HOUR = 2;
    localparam int unsigned A_DAY  = 3;
    localparam int unsigned A_DATE = 4;
    localparam int unsigned A_MON  = 5;
    localparam int unsigned A_YEAR = 6;
    localparam int unsigned A_CTRL = 7;
    localparam int unsigned A_RAM  = 8;

    localparam logic [7:0] M_MIN  = 8'h7F;
    localparam logic [7:0] M_HOUR = 8'hBF;
    localparam logic [7:0] M_HVAL = 8'h3F;
    localparam logic [7:0] M_DAY  = 8'h07;
    localparam logic [7:0] M_DATE = 8'h3F;
    localparam logic [7:0] M_MON  = 8'h1F;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return v + 8'd1;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int unsigned DIV = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic run,
    input  logic clear,
    output logic sec_pulse
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    assign sec_pulse = run && tick_en && !clear && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt_q <= '0;
        else if (run && tick_en)
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    AST_PULSE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |=> !sec_pulse); // R2
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0)); // R10

endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len (
    input  logic [7:0] month,
    input  logic       yr_tens_odd,
    input  logic [3:0] yr_ones,
    output logic [7:0] last_date
);
    logic leap;

    always_comb begin
        if (yr_tens_odd)
            leap = (yr_ones == 4'd2) || (yr_ones == 4'd6);
        else
            leap = (yr_ones == 4'd0) || (yr_ones == 4'd4) || (yr_ones == 4'd8);
        case (month)
            8'h02:                      last_date = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_date = 8'h30;
            default:                    last_date = 8'h31;
        endcase
    end

endmodule

// File: rtl/rtc_scratch_ram.sv
module rtc_scratch_ram #(
    parameter int unsigned AW   = 6,
    parameter int unsigned BASE = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    localparam int unsigned N  = (1 << AW) - BASE;
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

    logic [7:0]    mem [N];
    logic          hit;
    logic [AW-1:0] off;
    logic [IW-1:0] idx;

    assign hit = (addr >= AW'(BASE));
    assign off = addr - AW'(BASE);
    assign idx = off[IW-1:0];
    assign rdata = hit ? mem[idx] : 8'h00;

    always_ff @(posedge clk) begin
        if (we && hit)
            mem[idx] <= wdata;
    end

endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
    import rtc_pkg::*;
#(
    parameter int unsigned TICK_DIV = 32768,
    parameter int unsigned ADDR_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata
);
    rtc_state_e state_q, state_d;

    logic [7:0] sec_q, min_q, hr_q, day_q, date_q, mon_q, yr_q, ctrl_q;
    logic [7:0] last_date, ram_rdata;
    logic       sec_pulse;
    logic       wr_sec, wr_min, wr_hr, wr_day, wr_date, wr_mon, wr_yr, wr_ctrl;

    assign wr_sec  = reg_we && (reg_addr == ADDR_W'(A_SEC));
    assign wr_min  = reg_we && (reg_addr == ADDR_W'(A_MIN));
    assign wr_hr   = reg_we && (reg_addr == ADDR_W'(A_HOUR));
    assign wr_day  = reg_we && (reg_addr == ADDR_W'(A_DAY));
    assign wr_date = reg_we && (reg_addr == ADDR_W'(A_DATE));
    assign wr_mon  = reg_we && (reg_addr == ADDR_W'(A_MON));
    assign wr_yr   = reg_we && (reg_addr == ADDR_W'(A_YEAR));
    assign wr_ctrl = reg_we && (reg_addr == ADDR_W'(A_CTRL));

    rtc_prescaler #(.DIV(TICK_DIV)) u_prescaler (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .run       (!sec_q[7]),
        .clear     (wr_sec),
        .sec_pulse (sec_pulse)
    );

    rtc_month_len u_month_len (
        .month       (mon_q),
        .yr_tens_odd (yr_q[4]),
        .yr_ones     (yr_q[3:0]),
        .last_date   (last_date)
    );

    rtc_scratch_ram #(.AW(ADDR_W), .BASE(A_RAM)) u_ram (
        .clk   (clk),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (ram_rdata)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Carry sequencing
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE:  state_d = sec_pulse ? ST_SEC : ST_IDLE;
            ST_SEC:   if (!wr_sec && !sec_q[7] && sec_q[6:0] >= 7'h59) state_d = ST_MIN;
            ST_MIN:   if (!wr_min && min_q >= 8'h59) state_d = ST_HOUR;
            ST_HOUR:  if (!wr_hr && (hr_q & M_HVAL) >= 8'h23) state_d = ST_DAY;
            ST_DAY:   state_d = ST_DATE;
            ST_DATE:  if (!wr_date && date_q >= last_date) state_d = ST_MONTH;
            ST_MONTH: if (!wr_mon && mon_q >= 8'h12) state_d = ST_YEAR;
            ST_YEAR:  state_d = ST_IDLE;
        endcase
    end

    // Register updates: port write first, then carry step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q  <= 8'h00;
            min_q  <= 8'h00;
            hr_q   <= 8'h00;
            day_q  <= 8'h01;
            date_q <= 8'h01;
            mon_q  <= 8'h01;
            yr_q   <= 8'h00;
            ctrl_q <= 8'h00;
        end else begin
            if (wr_sec)
                sec_q <= reg_wdata;
            else if (state_q == ST_SEC && !sec_q[7])
                sec_q <= (sec_q[6:0] >= 7'h59) ? 8'h00 : bcd_inc(sec_q);

            if (wr_min)
                min_q <= reg_wdata & M_MIN;
            else if (state_q == ST_MIN)
                min_q <= (min_q >= 8'h59) ? 8'h00 : bcd_inc(min_q);

            if (wr_hr)
                hr_q <= reg_wdata & M_HOUR;
            else if (state_q == ST_HOUR)
                hr_q <= (hr_q & 8'h80) |
                        (((hr_q & M_HVAL) >= 8'h23) ? 8'h00 : (bcd_inc(hr_q & M_HVAL) & M_HVAL));
            else if (state_q == ST_YEAR && yr_q >= 8'h99)
                hr_q <= hr_q ^ 8'h80;

            if (wr_day)
                day_q <= reg_wdata & M_DAY;
            else if (state_q == ST_DAY)
                day_q <= (day_q >= 8'h07) ? 8'h01 : day_q + 8'h01;

            if (wr_date)
                date_q <= reg_wdata & M_DATE;
            else if (state_q == ST_DATE)
                date_q <= (date_q >= last_date) ? 8'h01 : bcd_inc(date_q);

            if (wr_mon)
                mon_q <= reg_wdata & M_MON;
            else if (state_q == ST_MONTH)
                mon_q <= (mon_q >= 8'h12) ? 8'h01 : bcd_inc(mon_q);

            if (wr_yr)
                yr_q <= reg_wdata;
            else if (state_q == ST_YEAR)
                yr_q <= (yr_q >= 8'h99) ? 8'h00 : bcd_inc(yr_q);

            if (wr_ctrl)
                ctrl_q <= reg_wdata;
        end
    end

    // Read mux
    always_comb begin
        if (reg_addr == ADDR_W'(A_SEC))       reg_rdata = sec_q;
        else if (reg_addr == ADDR_W'(A_MIN))  reg_rdata = min_q;
        else if (reg_addr == ADDR_W'(A_HOUR)) reg_rdata = hr_q;
        else if (reg_addr == ADDR_W'(A_DAY))  reg_rdata = day_q;
        else if (reg_addr == ADDR_W'(A_DATE)) reg_rdata = date_q;
        else if (reg_addr == ADDR_W'(A_MON))  reg_rdata = mon_q;
        else if (reg_addr == ADDR_W'(A_YEAR)) reg_rdata = yr_q;
        else if (reg_addr == ADDR_W'(A_CTRL)) reg_rdata = ctrl_q;
        else                                  reg_rdata = ram_rdata;
    end

    AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_q[7] && !wr_sec) |=> $stable(sec_q)); // R9
    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sec |=> (sec_q == $past(reg_wdata))); // R10
    AST_CENTURY_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_YEAR && yr_q == 8'h99 && !wr_hr) |=> (hr_q[7] != $past(hr_q[7]))); // R8
    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEC && !wr_sec && sec_q == 8'h59) |=> (sec_q == 8'h00 && state_q == ST_MIN)); // R3
    AST_DAY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DAY && !wr_day && day_q == 8'h07) |=> (day_q == 8'h01)); // R5
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEC && wr_sec) |=> (state_q == ST_IDLE)); // R11

endmodule

// File: tb/rtc_bcd_core_tb.sv
module rtc_bcd_core_tb;
    localparam int D = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b1;
    logic [5:0] reg_addr = '0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rtc_bcd_core #(.TICK_DIV(D), .ADDR_W(6)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = 6'(a); reg_wdata = d; reg_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic chk(input string tag, input int a, input logic [7:0] exp);
        reg_addr = 6'(a);
        #1;
        checks++;
        if (reg_rdata !== exp) begin
            failures++;
            $display("FAIL %s addr=%0d actual=%02h expected=%02h", tag, a, reg_rdata, exp);
        end
    endtask

    // packed as {sec,min,hr,day,date,mon,yr}
    task automatic load_time(input logic [55:0] v);
        wr(0, 8'h80);
        for (int a = 1; a < 7; a++) wr(a, v[55-8*a -: 8]);
        wr(0, v[55:48]);
    endtask

    task automatic chk_all(input string tag, input logic [55:0] v);
        for (int a = 0; a < 7; a++) chk(tag, a, v[55-8*a -: 8]);
    endtask

    task automatic step_case(input string tag, input logic [55:0] s, input logic [55:0] e);
        load_time(s);
        repeat (D + 8) @(negedge clk);
        chk_all(tag, e);
    endtask

    task automatic t_reset;
        chk_all("R1", {8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00});
        chk("R1", 7, 8'h00);
    endtask

    task automatic t_tick_count;
        load_time({8'h05, 8'h10, 8'h08, 8'h02, 8'h11, 8'h06, 8'h21});
        repeat (D) @(negedge clk);
        chk("R2 before", 0, 8'h05);
        @(negedge clk);
        chk("R2 after", 0, 8'h06);
        load_time({8'h07, 8'h10, 8'h08, 8'h02, 8'h11, 8'h06, 8'h21});
        tick_en = 1'b0;
        repeat (3 * D) @(negedge clk);
        chk("R2 no tick", 0, 8'h07);
        tick_en = 1'b1;
        repeat (D + 2) @(negedge clk);
        chk("R2 resume", 0, 8'h08);
    endtask

    task automatic t_stop;
        load_time({8'h30, 8'h10, 8'h08, 8'h02, 8'h11, 8'h06, 8'h21});
        wr(0, 8'hB0);
        repeat (3 * D) @(negedge clk);
        chk("R9 frozen", 0, 8'hB0);
        chk("R9 min", 1, 8'h10);
        wr(0, 8'h30);
        repeat (D + 8) @(negedge clk);
        chk("R9 restart", 0, 8'h31);
    endtask

    task automatic t_clear;
        load_time({8'h10, 8'h10, 8'h08, 8'h02, 8'h11, 8'h06, 8'h21});
        repeat (8) @(negedge clk);
        wr(0, 8'h20);
        repeat (D) @(negedge clk);
        chk("R10 cleared", 0, 8'h20);
        repeat (2) @(negedge clk);
        chk("R10 step", 0, 8'h21);
    endtask

    task automatic t_collision;
        load_time({8'h59, 8'h10, 8'h08, 8'h02, 8'h11, 8'h06, 8'h21});
        repeat (D - 1) @(negedge clk);
        wr(0, 8'h20);
        repeat (4) @(negedge clk);
        chk("R11 sec", 0, 8'h20);
        chk("R11 min", 1, 8'h10);
    endtask

    task automatic t_storage;
        wr(7, 8'hA5);
        wr(8, 8'h3C);
        wr(63, 8'hC3);
        wr(30, 8'h5A);
        load_time({8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99});
        repeat (D + 8) @(negedge clk);
        chk("R12 ctrl", 7, 8'hA5);
        chk("R12 ram lo", 8, 8'h3C);
        chk("R12 ram hi", 63, 8'hC3);
        chk("R12 ram mid", 30, 8'h5A);
    endtask

    task automatic t_masks;
        wr(0, 8'h80);
        wr(1, 8'hFF); chk("R13 min", 1, 8'h7F);
        wr(2, 8'hFF); chk("R13 hour", 2, 8'hBF);
        wr(3, 8'hFF); chk("R13 day", 3, 8'h07);
        wr(4, 8'hFF); chk("R13 date", 4, 8'h3F);
        wr(5, 8'hFF); chk("R13 month", 5, 8'h1F);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tick_count();
        step_case("R3 sec wrap",  {8'h59, 8'h34, 8'h12, 8'h03, 8'h10, 8'h05, 8'h21},
                                  {8'h00, 8'h35, 8'h12, 8'h03, 8'h10, 8'h05, 8'h21});
        step_case("R3 min wrap",  {8'h59, 8'h59, 8'h12, 8'h03, 8'h10, 8'h05, 8'h21},
                                  {8'h00, 8'h00, 8'h13, 8'h03, 8'h10, 8'h05, 8'h21});
        step_case("R4 R5 hour",   {8'h59, 8'h59, 8'h23, 8'h07, 8'h15, 8'h03, 8'h21},
                                  {8'h00, 8'h00, 8'h00, 8'h01, 8'h16, 8'h03, 8'h21});
        step_case("R5 weekday",   {8'h59, 8'h59, 8'h23, 8'h04, 8'h15, 8'h03, 8'h21},
                                  {8'h00, 8'h00, 8'h00, 8'h05, 8'h16, 8'h03, 8'h21});
        step_case("R6 apr30",     {8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h21},
                                  {8'h00, 8'h00, 8'h00, 8'h03, 8'h01, 8'h05, 8'h21});
        step_case("R6 jan30",     {8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h01, 8'h21},
                                  {8'h00, 8'h00, 8'h00, 8'h03, 8'h31, 8'h01, 8'h21});
        step_case("R6 jan31",     {8'h59, 8'h59, 8'h23, 8'h02, 8'h31, 8'h01, 8'h21},
                                  {8'h00, 8'h00, 8'h00, 8'h03, 8'h01, 8'h02, 8'h21});
        step_case("R7 feb28 y23", {8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23},
                                  {8'h00, 8'h00, 8'h00, 8'h03, 8'h01, 8'h03, 8'h23});
        step_case("R7 feb28 y24", {8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24},
                                  {8'h00, 8'h00, 8'h00, 8'h03, 8'h29, 8'h02, 8'h24});
        step_case("R7 feb29 y24", {8'h59, 8'h59, 8'h23, 8'h02, 8'h29, 8'h02, 8'h24},
                                  {8'h00, 8'h00, 8'h00, 8'h03, 8'h01, 8'h03, 8'h24});
        step_case("R7 feb28 y12", {8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h12},
                                  {8'h00, 8'h00, 8'h00, 8'h03, 8'h29, 8'h02, 8'h12});
        step_case("R7 feb28 y10", {8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h10},
                                  {8'h00, 8'h00, 8'h00, 8'h03, 8'h01, 8'h03, 8'h10});
        step_case("R6 R8 y99",    {8'h59, 8'h59, 8'h23, 8'h06, 8'h31, 8'h12, 8'h99},
                                  {8'h00, 8'h00, 8'h80, 8'h07, 8'h01, 8'h01, 8'h00});
        step_case("R8 cent set",  {8'h59, 8'h59, 8'hA3, 8'h06, 8'h31, 8'h12, 8'h99},
                                  {8'h00, 8'h00, 8'h00, 8'h07, 8'h01, 8'h01, 8'h00});
        step_case("R6 dec30",     {8'h59, 8'h59, 8'h23, 8'h06, 8'h30, 8'h12, 8'h45},
                                  {8'h00, 8'h00, 8'h00, 8'h07, 8'h31, 8'h12, 8'h45});
        t_stop();
        t_clear();
        t_collision();
        t_storage();
        t_masks();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule